// File: doc/BRIEF.md
# Locked Volatile Key Test Port

This block is a boundary-test access port, driven by its own test clock, that guards a volatile security key. A 10-bit instruction register selects what the serial data path does. On power-up the port allows only the plain test instructions. The key-program and key-invalidate instructions stay closed until an unlock opcode has been executed. Unlocking also strobes a configuration-clear output and wipes any stored key.

When the key-program instruction is active, serial input bits feed a 512-bit staging chain. On Update-DR the staging chain is copied to a shadow register that drives the key output, and a verify flag marks the key as valid. The chain is write-only: the serial output stays at zero while key bits shift. A second key cannot overwrite the first while the verify flag is set. The flag is cleared only when the invalidate instruction stays active for ten consecutive test-clock edges.

A status input reports that device configuration is running. While it is high, only the bypass, identification, sample and configuration-interrupt instructions are granted, unless the interrupt instruction has been executed since reset. The boundary register itself sits outside this block, so the sample and external-test instructions route data through the single-bit bypass stage here.

Top module: `vkey_tap`

## Requirements
- R1: The port uses the standard 16-state TAP controller, clocked on rising `tck_i`. Five consecutive edges with `tms_i` high, or `rst_ni` low (asynchronous), reach Test-Logic-Reset. In Test-Logic-Reset the identification instruction is selected, and its 32-bit data register captures the ID value and shifts it out least significant bit first.
- R2: The instruction register is 10 bits wide and shifts least significant bit first. Capture-IR loads 10'b0000000001. The opcodes are: bypass 11_1111_1111, sample 00_0000_0101, external test 00_0000_1111, identification 00_0000_0110, configuration interrupt 00_0000_1101, unlock 10_1000_0001, key program 01_1010_1101, invalidate 00_0010_1001.
- R3: Until unlock has been executed after `rst_ni`, key program and invalidate are refused and act as bypass. Bypass is a 1-bit register that captures 0, so n shifted bits come out as the input moved up one place.
- R4: A granted unlock raises `cfg_clear_o` for exactly one cycle, starting at the edge that leaves Update-IR. On the next edge, `key_o` becomes zero and `key_valid_o` goes low.
- R5: With key program granted, the bits shifted in Shift-DR fill a 512-bit chain least significant bit first. If `key_valid_o` is low at Update-DR, that edge copies the chain to `key_o` and sets `key_valid_o`.
- R6: `tdo_o` is 0 during every Shift-DR cycle of the key-program instruction.
- R7: An Update-DR under key program while `key_valid_o` is high leaves `key_o` and `key_valid_o` unchanged.
- R8: `key_valid_o` falls on the tenth consecutive rising edge at which the invalidate instruction is active. If the instruction is left after nine or fewer such edges, the flag stays set.
- R9: While `cfg_busy_i` is high and no configuration interrupt has been granted since reset, only bypass, sample, identification and configuration interrupt are granted. Any other opcode loaded at Update-IR acts as bypass.
- R10: An opcode not listed in R2 acts as bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset, also the power-on reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| cfg_busy_i | input | 1 | High while device configuration runs |
| tdo_o | output | 1 | Serial data out (0 outside shift states) |
| key_o | output | 512 | Stored volatile key |
| key_valid_o | output | 1 | Verify flag: stored key is valid |
| cfg_clear_o | output | 1 | One-cycle request to clear configuration data |

## Verification
The assertions assume the following about the inputs:
- `rst_ni` is low before the first clock edge.
- `tms_i` and `tdi_i` change only away from the rising edge.
- `cfg_busy_i` is steady whenever an Update-IR edge decides a grant.

The bench keeps within these assumptions:
- It drives all serial inputs on the falling edge.
- It changes `cfg_busy_i` only while the controller idles in Run-Test/Idle.
- It times invalidate holds by counting whole controller steps from the Update-IR edge.

// File: rtl/vkey_pkg.sv
package vkey_pkg;
  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    I_BYPASS, I_SAMPLE, I_EXTEST, I_IDCODE, I_CFGINT, I_UNLOCK, I_KEYPROG, I_CLRV
  } instr_e;

  localparam logic [IR_W-1:0] OP_BYPASS  = 10'b11_1111_1111;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'b00_0000_0101;
  localparam logic [IR_W-1:0] OP_EXTEST  = 10'b00_0000_1111;
  localparam logic [IR_W-1:0] OP_IDCODE  = 10'b00_0000_0110;
  localparam logic [IR_W-1:0] OP_CFGINT  = 10'b00_0000_1101;
  localparam logic [IR_W-1:0] OP_UNLOCK  = 10'b10_1000_0001;
  localparam logic [IR_W-1:0] OP_KEYPROG = 10'b01_1010_1101;
  localparam logic [IR_W-1:0] OP_CLRV    = 10'b00_0010_1001;

  function automatic instr_e op_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_SAMPLE:  return I_SAMPLE;
      OP_EXTEST:  return I_EXTEST;
      OP_IDCODE:  return I_IDCODE;
      OP_CFGINT:  return I_CFGINT;
      OP_UNLOCK:  return I_UNLOCK;
      OP_KEYPROG: return I_KEYPROG;
      OP_CLRV:    return I_CLRV;
      default:    return I_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/vkey_tap_fsm.sv
module vkey_tap_fsm
  import vkey_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:      state_d = tms_i ? ST_TLR      : ST_RTI;
      ST_RTI:      state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      ST_SEL_DR:   state_d = tms_i ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: state_d = tms_i ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_d = tms_i ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: state_d = tms_i ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      ST_SEL_IR:   state_d = tms_i ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: state_d = tms_i ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_d = tms_i ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: state_d = tms_i ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      default:     state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/vkey_tap_ir.sv
module vkey_tap_ir
  import vkey_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  input  logic       cfg_busy_i,
  output logic       ir_tdo_o,
  output instr_e     instr_o,
  output logic       unlocked_o,
  output logic       cfg_clear_o
);
  logic [IR_W-1:0] ir_sr;
  instr_e          instr_q, kind, grant;
  logic            unlocked_q, cfg_intr_q, clear_q;
  logic            open_lock, open_cfg, upd;

  // Gate on lock and configuration status at the moment the opcode is committed
  always_comb begin
    kind      = op_decode(ir_sr);
    open_lock = unlocked_q ||
                (kind inside {I_BYPASS, I_SAMPLE, I_EXTEST, I_IDCODE, I_UNLOCK, I_CFGINT});
    open_cfg  = !cfg_busy_i || cfg_intr_q ||
                (kind inside {I_BYPASS, I_SAMPLE, I_IDCODE, I_CFGINT});
    grant     = (open_lock && open_cfg) ? kind : I_BYPASS;
    upd       = (state_i == ST_UPD_IR);
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_sr      <= '0;
      instr_q    <= I_IDCODE;
      unlocked_q <= 1'b0;
      cfg_intr_q <= 1'b0;
      clear_q    <= 1'b0;
    end else begin
      clear_q <= upd && (grant == I_UNLOCK);
      case (state_i)
        ST_CAP_IR:   ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
        ST_SHIFT_IR: ir_sr <= {tdi_i, ir_sr[IR_W-1:1]};
        default:     ;
      endcase
      if (state_i == ST_TLR) instr_q <= I_IDCODE;
      else if (upd)          instr_q <= grant;
      if (upd && grant == I_UNLOCK) unlocked_q <= 1'b1;
      if (upd && grant == I_CFGINT) cfg_intr_q <= 1'b1;
    end
  end

  assign ir_tdo_o    = ir_sr[0];
  assign instr_o     = instr_q;
  assign unlocked_o  = unlocked_q;
  assign cfg_clear_o = clear_q;
endmodule

// File: rtl/vkey_store.sv
module vkey_store
  import vkey_pkg::*;
#(
  parameter int KEY_W    = 512,
  parameter int CLR_HOLD = 10
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  tap_state_e       state_i,
  input  instr_e           instr_i,
  input  logic             tdi_i,
  input  logic             erase_i,
  output logic [KEY_W-1:0] key_o,
  output logic             valid_o
);
  localparam int CNT_W = $clog2(CLR_HOLD + 1);

  logic [KEY_W-1:0] key_sr, key_q;
  logic [CNT_W-1:0] hold_q;
  logic             valid_q, is_prog, is_clr;

  assign is_prog = (instr_i == I_KEYPROG);
  assign is_clr  = (instr_i == I_CLRV);

  // Consecutive edges with invalidate active, saturating
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                        hold_q <= '0;
    else if (!is_clr)                   hold_q <= '0;
    else if (hold_q != CNT_W'(CLR_HOLD)) hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_sr  <= '0;
      key_q   <= '0;
      valid_q <= 1'b0;
    end else if (erase_i) begin
      key_sr  <= '0;
      key_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (is_prog && state_i == ST_SHIFT_DR) key_sr <= {tdi_i, key_sr[KEY_W-1:1]};
      if (is_clr && hold_q == CNT_W'(CLR_HOLD - 1)) begin
        valid_q <= 1'b0;
      end else if (is_prog && state_i == ST_UPD_DR && !valid_q) begin
        key_q   <= key_sr;
        valid_q <= 1'b1;
      end
    end
  end

  assign key_o   = key_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/vkey_tap.sv
module vkey_tap
  import vkey_pkg::*;
#(
  parameter int          KEY_W    = 512,
  parameter int          CLR_HOLD = 10,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_C0DD
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  input  logic             cfg_busy_i,
  output logic             tdo_o,
  output logic [KEY_W-1:0] key_o,
  output logic             key_valid_o,
  output logic             cfg_clear_o
);
  localparam int ID_W = $bits(ID_VALUE);

  tap_state_e      tap_state;
  instr_e          instr;
  logic            unlocked, ir_tdo, byp_q;
  logic [ID_W-1:0] id_sr;

  vkey_tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(tap_state)
  );

  vkey_tap_ir u_ir (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .state_i    (tap_state),
    .tdi_i      (tdi_i),
    .cfg_busy_i (cfg_busy_i),
    .ir_tdo_o   (ir_tdo),
    .instr_o    (instr),
    .unlocked_o (unlocked),
    .cfg_clear_o(cfg_clear_o)
  );

  vkey_store #(
    .KEY_W   (KEY_W),
    .CLR_HOLD(CLR_HOLD)
  ) u_store (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .state_i(tap_state),
    .instr_i(instr),
    .tdi_i  (tdi_i),
    .erase_i(cfg_clear_o),
    .key_o  (key_o),
    .valid_o(key_valid_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_sr <= '0;
    end else if (tap_state == ST_CAP_DR) begin
      byp_q <= 1'b0;
      id_sr <= ID_VALUE;
    end else if (tap_state == ST_SHIFT_DR) begin
      byp_q <= tdi_i;
      id_sr <= {tdi_i, id_sr[ID_W-1:1]};
    end
  end

  // Key chain never reaches the serial output
  always_comb begin
    tdo_o = 1'b0;
    if (tap_state == ST_SHIFT_IR) tdo_o = ir_tdo;
    else if (tap_state == ST_SHIFT_DR) begin
      case (instr)
        I_IDCODE:  tdo_o = id_sr[0];
        I_KEYPROG: tdo_o = 1'b0;
        default:   tdo_o = byp_q;
      endcase
    end
  end

  logic unused_unlocked;
  assign unused_unlocked = unlocked;
endmodule

// File: rtl/vkey_tap_chk.sv
module vkey_tap_chk
  import vkey_pkg::*;
#(
  parameter int KEY_W = 512
) (
  input logic             tck_i,
  input logic             rst_ni,
  input tap_state_e       state_i,
  input instr_e           instr_i,
  input logic             unlocked_i,
  input logic             tdo_i,
  input logic [KEY_W-1:0] key_i,
  input logic             valid_i,
  input logic             clr_i
);
  a_r1_tlr_idcode: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> instr_i == I_IDCODE);

  a_r3_locked_gate: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !unlocked_i |-> !(instr_i inside {I_KEYPROG, I_CLRV}));

  a_r4_clear_single: assert property (@(posedge tck_i) disable iff (!rst_ni)
    clr_i |=> !clr_i);

  a_r4_clear_erases: assert property (@(posedge tck_i) disable iff (!rst_ni)
    clr_i |=> (key_i == '0) && !valid_i);

  a_r6_tdo_silent: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SHIFT_DR && instr_i == I_KEYPROG) |-> !tdo_i);

  a_r7_key_hold: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (valid_i && !clr_i) |=> $stable(key_i));

  a_r8_valid_fall_cause: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $fell(valid_i) |-> ($past(instr_i) == I_CLRV || $past(clr_i)));
endmodule

bind vkey_tap vkey_tap_chk #(.KEY_W(KEY_W)) u_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .state_i   (tap_state),
  .instr_i   (instr),
  .unlocked_i(unlocked),
  .tdo_i     (tdo_o),
  .key_i     (key_o),
  .valid_i   (key_valid_o),
  .clr_i     (cfg_clear_o)
);

// File: tb/vkey_tap_tb_top.sv
module vkey_tap_tb_top;
  localparam int          TCK_PERIOD = 10;
  localparam int          KEY_W      = 512;
  localparam logic [31:0] ID_VAL     = 32'h1A2B_C0DD;

  localparam logic [9:0] C_BYPASS  = 10'b11_1111_1111;
  localparam logic [9:0] C_IDCODE  = 10'b00_0000_0110;
  localparam logic [9:0] C_CFGINT  = 10'b00_0000_1101;
  localparam logic [9:0] C_UNLOCK  = 10'b10_1000_0001;
  localparam logic [9:0] C_KEYPROG = 10'b01_1010_1101;
  localparam logic [9:0] C_CLRV    = 10'b00_0010_1001;
  localparam logic [9:0] C_UNKNOWN = 10'b00_0000_0000;

  localparam logic [KEY_W-1:0] K1 = {16{32'h5A3C_96E1}};
  localparam logic [KEY_W-1:0] K2 = {16{32'h0F1E_2D3B}};

  logic             tck = 1'b0;
  logic             rst_n = 1'b0;
  logic             tms = 1'b1;
  logic             tdi = 1'b0;
  logic             busy = 1'b0;
  logic             tdo;
  logic [KEY_W-1:0] key;
  logic             valid, clr;
  int               n_cmp = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #(TCK_PERIOD / 2) tck = ~tck;

  vkey_tap #(.KEY_W(KEY_W), .CLR_HOLD(10), .ID_VALUE(ID_VAL)) dut_i (
    .tck_i      (tck),
    .rst_ni     (rst_n),
    .tms_i      (tms),
    .tdi_i      (tdi),
    .cfg_busy_i (busy),
    .tdo_o      (tdo),
    .key_o      (key),
    .key_valid_o(valid),
    .cfg_clear_o(clr)
  );

  task automatic chk(input string what, input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // One controller step: drive on falling edge, sample TDO, let the rising edge pass
  task automatic step(input logic m, input logic d, output logic q);
    @(negedge tck);
    tms = m;
    tdi = d;
    #1 q = tdo;
    @(posedge tck);
    #1;
  endtask

  task automatic idle(input int n);
    logic q;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, q);
  endtask

  task automatic shift_ir(input logic [9:0] op, output logic [9:0] cap);
    logic q;
    step(1'b1, 1'b0, q);
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, op[i], q);
      cap[i] = q;
    end
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
  endtask

  task automatic shift_dr(input int n, input logic [KEY_W-1:0] din, output logic [KEY_W-1:0] dout);
    logic q;
    dout = '0;
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], q);
      dout[i] = q;
    end
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
  endtask

  task automatic t_reset();
    chk("R1 reset tdo", KEY_W'(tdo), '0);
    chk("R1 reset key", key, '0);
    chk("R1 reset valid", KEY_W'(valid), '0);
    chk("R4 reset clear", KEY_W'(clr), '0);
  endtask

  task automatic t_idcode();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    logic             q;
    idle(1);
    shift_dr(32, '0, o);
    chk("R1 idcode after reset", KEY_W'(o[31:0]), KEY_W'(ID_VAL));
    shift_ir(C_BYPASS, cap);
    chk("R2 IR capture pattern", KEY_W'(cap), KEY_W'(10'b0000000001));
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    shift_dr(32, '0, o);
    chk("R1 five TMS high selects idcode", KEY_W'(o[31:0]), KEY_W'(ID_VAL));
  endtask

  task automatic t_unknown();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    shift_ir(C_UNKNOWN, cap);
    shift_dr(8, KEY_W'(8'hB5), o);
    chk("R10 unknown opcode bypass", KEY_W'(o[7:0]), KEY_W'(8'h6A));
  endtask

  task automatic t_locked();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    shift_ir(C_KEYPROG, cap);
    shift_dr(8, KEY_W'(8'hFF), o);
    chk("R3 locked keyprog acts as bypass", KEY_W'(o[7:0]), KEY_W'(8'hFE));
    chk("R3 locked key unchanged", key, '0);
    chk("R3 locked valid stays low", KEY_W'(valid), '0);
  endtask

  task automatic t_busy_gate();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    busy = 1'b1;
    shift_ir(C_UNLOCK, cap);
    chk("R9 unlock refused while busy", KEY_W'(clr), '0);
    shift_ir(C_IDCODE, cap);
    shift_dr(32, '0, o);
    chk("R9 idcode allowed while busy", KEY_W'(o[31:0]), KEY_W'(ID_VAL));
    shift_ir(C_CFGINT, cap);
    shift_ir(C_UNLOCK, cap);
    chk("R9 R4 unlock after interrupt pulses clear", KEY_W'(clr), 1);
    idle(1);
    chk("R4 clear lasts one cycle", KEY_W'(clr), '0);
    busy = 1'b0;
  endtask

  task automatic t_keyprog();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    shift_ir(C_KEYPROG, cap);
    shift_dr(KEY_W, K1, o);
    chk("R6 tdo silent while key shifts", o, '0);
    chk("R5 key loaded", key, K1);
    chk("R5 valid set", KEY_W'(valid), 1);
  endtask

  task automatic t_key_hold();
    logic [KEY_W-1:0] o;
    shift_dr(KEY_W, K2, o);
    chk("R7 key kept while valid", key, K1);
    chk("R7 valid kept", KEY_W'(valid), 1);
    chk("R6 tdo silent on second shift", o, '0);
  endtask

  task automatic t_clrv_short();
    logic [9:0] cap;
    logic       q;
    shift_ir(C_CLRV, cap);
    idle(5);
    step(1'b1, 1'b0, q);
    step(1'b1, 1'b0, q);
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    idle(3);
    chk("R8 nine-edge hold keeps flag", KEY_W'(valid), 1);
  endtask

  task automatic t_clrv_long();
    logic [9:0] cap;
    shift_ir(C_CLRV, cap);
    idle(9);
    chk("R8 flag set after nine edges", KEY_W'(valid), 1);
    idle(1);
    chk("R8 flag cleared on tenth edge", KEY_W'(valid), '0);
    chk("R8 key kept after invalidate", key, K1);
  endtask

  task automatic t_reprogram();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    shift_ir(C_KEYPROG, cap);
    shift_dr(KEY_W, K2, o);
    chk("R5 new key after invalidate", key, K2);
    chk("R5 valid set again", KEY_W'(valid), 1);
  endtask

  task automatic t_unlock_erase();
    logic [9:0] cap;
    shift_ir(C_UNLOCK, cap);
    chk("R4 clear pulse", KEY_W'(clr), 1);
    chk("R4 key held on pulse edge", key, K2);
    idle(1);
    chk("R4 clear drops", KEY_W'(clr), '0);
    chk("R4 key erased", key, '0);
    chk("R4 valid erased", KEY_W'(valid), '0);
  endtask

  task automatic t_trst();
    logic [KEY_W-1:0] o;
    logic [9:0]       cap;
    shift_ir(C_KEYPROG, cap);
    shift_dr(KEY_W, K1, o);
    chk("R5 key before test reset", key, K1);
    @(negedge tck);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async reset clears key", key, '0);
    chk("R1 async reset clears valid", KEY_W'(valid), '0);
    @(negedge tck);
    rst_n = 1'b1;
    idle(1);
    shift_ir(C_KEYPROG, cap);
    shift_dr(8, KEY_W'(8'hFF), o);
    chk("R3 relocked after reset", KEY_W'(o[7:0]), KEY_W'(8'hFE));
    chk("R3 key stays clear when relocked", key, '0);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge tck);
    #1 t_reset();
    @(negedge tck);
    rst_n = 1'b1;
    t_idcode();
    t_unknown();
    t_locked();
    t_busy_gate();
    t_keyprog();
    t_key_hold();
    t_clrv_short();
    t_clrv_long();
    t_reprogram();
    t_unlock_erase();
    t_trst();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule